// File: doc/BRIEF.md
# Packed Float-to-Integer Converter

This block takes a 64-bit word that holds two IEEE-754 single-precision numbers and turns each one into a signed integer. The two results are packed into a 64-bit output word. Both lanes are converted side by side. The unit has a two-stage pipeline. An input strobe qualifies the operands, and an output strobe follows exactly two cycles later. A new operand may be accepted on every cycle.

A 2-bit mode input picks one of four conversions:

- A 32-bit conversion that rounds as the 2-bit rounding-control input directs.
- A 32-bit conversion that always truncates toward zero.
- Two legacy conversions that truncate and saturate. One produces a 32-bit integer. The other produces a 16-bit integer, sign-extended to fill its 32-bit lane.

The non-legacy modes report NaN, infinity and out-of-range inputs as the integer-indefinite value. The legacy modes saturate instead.

Top module: `pf2i_conv`

## Requirements
- R1: Lane 0 takes its float from `op_i[31:0]` and writes its integer to `res_o[31:0]`. Lane 1 uses `op_i[63:32]` and `res_o[63:32]` in the same way. The two lanes are converted independently in the same cycle.
- R2: Each cycle with `in_valid_i` high produces exactly one cycle with `out_valid_o` high, two clock edges later. Strobes on consecutive cycles give results on consecutive cycles, in the same order.
- R3: In mode 0, an inexact value is rounded as `rc_i` selects. The encodings are 00 for nearest with ties to even, 01 toward negative infinity, 10 toward positive infinity, and 11 toward zero.
- R4: In mode 1, an inexact value is truncated toward zero, whatever the value of `rc_i`.
- R5: In modes 0 and 1, an input with exponent field 255 (NaN or infinity) gives 0x80000000. So does any value whose rounded result lies outside the signed 32-bit range.
- R6: In modes 0 and 1, a denormal input (exponent field 0, fraction not zero) converts to 0. The exception is a rounding direction that moves away from zero: then it converts to +1 for a positive input, or to -1 (0xFFFFFFFF) for a negative one.
- R7: In mode 2, the value is truncated toward zero to a signed 32-bit integer. Values above the range give 0x7FFFFFFF, and values below it give 0x80000000.
- R8: In mode 3, the value is truncated toward zero to a signed 16-bit integer. Values above the range give 0x7FFF, and values below it give 0x8000. The 16-bit result is sign-extended to fill its 32-bit lane.
- R9: A positive or negative zero gives 0 in every mode.
- R10: While reset is asserted, `out_valid_o` and `res_o` are 0. Between output strobes, `res_o` holds the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input strobe qualifying mode_i, rc_i and op_i |
| mode_i | input | 2 | 0 rounded 32-bit, 1 truncated 32-bit, 2 legacy 32-bit, 3 legacy 16-bit |
| rc_i | input | 2 | Rounding control used in mode 0 |
| op_i | input | 64 | Two packed single-precision operands |
| out_valid_o | output | 1 | Output strobe, two cycles after the input strobe |
| res_o | output | 64 | Two packed signed integer results |

## Verification
The rounding modes are tried with positive and negative values whose fractions are exactly one half, above one half and below one half. This separates ties-to-even from the directed and truncating choices, and it exposes sign errors in the increment. Boundary values are also driven:

- The largest float below 2^31.
- Exactly -2^31.
- Magnitudes just past the 16-bit limits.

These tell saturation apart from indefinite reporting and from off-by-one range compares. Denormals under every rounding direction show whether the sticky information survives for values far below one. Operand pairs with different values in each lane, sent both back to back and with gaps, catch swapped lanes and lost or reordered strobes.

// File: rtl/pf2i_pkg.sv
package pf2i_pkg;
  localparam int unsigned FLT_W = 32;
  localparam int unsigned MAG_W = 31;

  typedef enum logic [1:0] {
    MODE_RC    = 2'd0,
    MODE_TRUNC = 2'd1,
    MODE_LEG32 = 2'd2,
    MODE_LEG16 = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    RC_NEAR = 2'd0,
    RC_DOWN = 2'd1,
    RC_UP   = 2'd2,
    RC_ZERO = 2'd3
  } rc_e;

  // decoded lane between the two stages
  typedef struct packed {
    logic             sign;
    logic             ovf;     // |x| >= 2^31, inf or NaN
    logic             half;    // first fraction bit below the integer
    logic             sticky;  // any lower fraction bit
    logic [MAG_W-1:0] mag;     // truncated integer magnitude
  } dec_t;
endpackage

// File: rtl/pf2i_unpack.sv
module pf2i_unpack
  import pf2i_pkg::*;
(
  input  logic [FLT_W-1:0] flt_i,
  output dec_t             dec_o
);
  logic [7:0]  exp_f;
  logic [22:0] frac_f;
  logic [4:0]  shamt;
  logic [53:0] fixed;

  always_comb begin
    exp_f  = flt_i[30:23];
    frac_f = flt_i[22:0];
    // exp - 127 modulo 32
    shamt  = exp_f[4:0] + 5'd1;
    fixed  = {30'b0, 1'b1, frac_f} << shamt;
    dec_o      = '0;
    dec_o.sign = flt_i[31];
    if (exp_f >= 8'd158) begin
      dec_o.ovf = 1'b1;
    end else if (exp_f >= 8'd127) begin
      dec_o.mag    = fixed[53:23];
      dec_o.half   = fixed[22];
      dec_o.sticky = |fixed[21:0];
    end else if (exp_f == 8'd126) begin
      dec_o.half   = 1'b1;
      dec_o.sticky = |frac_f;
    end else if (exp_f != 8'd0 || frac_f != 23'd0) begin
      dec_o.sticky = 1'b1;
    end
  end
endmodule

// File: rtl/pf2i_finish.sv
module pf2i_finish
  import pf2i_pkg::*;
(
  input  dec_t        dec_i,
  input  mode_e       mode_i,
  input  rc_e         rc_i,
  output logic [31:0] res_o
);
  rc_e         rmode;
  logic        inc;
  logic        lost;
  logic [31:0] rmag;
  logic [31:0] sval;
  logic        sat16;

  always_comb begin
    rmode = (mode_i == MODE_RC) ? rc_i : RC_ZERO;
    lost  = dec_i.half | dec_i.sticky;
    unique case (rmode)
      RC_NEAR: inc = dec_i.half & (dec_i.sticky | dec_i.mag[0]);
      RC_DOWN: inc = dec_i.sign & lost;
      RC_UP:   inc = ~dec_i.sign & lost;
      default: inc = 1'b0;
    endcase
    rmag  = {1'b0, dec_i.mag} + {31'b0, inc};
    sval  = dec_i.sign ? (32'd0 - rmag) : rmag;
    sat16 = dec_i.ovf
          | (!dec_i.sign && dec_i.mag > 31'd32767)
          | ( dec_i.sign && dec_i.mag > 31'd32768);
    unique case (mode_i)
      MODE_RC, MODE_TRUNC: res_o = dec_i.ovf ? 32'h8000_0000 : sval;
      MODE_LEG32: res_o = !dec_i.ovf ? sval
                        : (dec_i.sign ? 32'h8000_0000 : 32'h7FFF_FFFF);
      default:    res_o = !sat16 ? sval
                        : (dec_i.sign ? 32'hFFFF_8000 : 32'h0000_7FFF);
    endcase
  end
endmodule

// File: rtl/pf2i_conv.sv
module pf2i_conv
  import pf2i_pkg::*;
#(
  parameter int unsigned NLANE = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   in_valid_i,
  input  logic [1:0]             mode_i,
  input  logic [1:0]             rc_i,
  input  logic [NLANE*FLT_W-1:0] op_i,
  output logic                   out_valid_o,
  output logic [NLANE*FLT_W-1:0] res_o
);
  localparam int unsigned W = NLANE * FLT_W;

  logic             v1_q;
  mode_e            mode_q;
  rc_e              rc_q;
  dec_t [NLANE-1:0] dec_d, dec_q;
  logic [W-1:0]     res_d;
  logic [W-1:0]     res_q;
  logic             v2_q;

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    pf2i_unpack u_unpack (
      .flt_i (op_i[l*FLT_W +: FLT_W]),
      .dec_o (dec_d[l])
    );
    pf2i_finish u_finish (
      .dec_i  (dec_q[l]),
      .mode_i (mode_q),
      .rc_i   (rc_q),
      .res_o  (res_d[l*FLT_W +: FLT_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q   <= 1'b0;
      mode_q <= MODE_RC;
      rc_q   <= RC_NEAR;
      dec_q  <= '0;
    end else begin
      v1_q <= in_valid_i;
      if (in_valid_i) begin
        mode_q <= mode_e'(mode_i);
        rc_q   <= rc_e'(rc_i);
        dec_q  <= dec_d;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v2_q  <= 1'b0;
      res_q <= '0;
    end else begin
      v2_q <= v1_q;
      if (v1_q) res_q <= res_d;
    end
  end

  assign out_valid_o = v2_q;
  assign res_o       = res_q;
endmodule

// File: rtl/pf2i_conv_chk.sv
module pf2i_conv_chk #(
  parameter int unsigned NLANE = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                in_valid_i,
  input logic [1:0]          mode_i,
  input logic [NLANE*32-1:0] op_i,
  input logic                out_valid_o,
  input logic [NLANE*32-1:0] res_o
);
  logic [1:0]          mode_d1, mode_d2;
  logic [NLANE*32-1:0] op_d1, op_d2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_d1 <= '0;
      mode_d2 <= '0;
      op_d1   <= '0;
      op_d2   <= '0;
    end else begin
      mode_d1 <= mode_i;
      mode_d2 <= mode_d1;
      op_d1   <= op_i;
      op_d2   <= op_d1;
    end
  end

  // R2
  lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> ##1 out_valid_o);

  // R2
  no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ##1 !out_valid_o);

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(res_o));

  // R9
  zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && op_d2[30:0] == 31'd0) |-> res_o[31:0] == 32'd0);

  // R5
  indef_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !mode_d2[1] && op_d2[30:23] == 8'hFF)
      |-> res_o[31:0] == 32'h8000_0000);

  // R8
  sext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && mode_d2 == 2'd3)
      |-> (res_o[31:15] == 17'd0 || res_o[31:15] == 17'h1FFFF));
endmodule

bind pf2i_conv pf2i_conv_chk #(.NLANE(NLANE)) u_chk (.*);

// File: tb/tb_pf2i_conv.sv
`timescale 1ns/1ps
module tb_pf2i_conv;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [1:0]  rc_i = '0;
  logic [63:0] op_i = '0;
  logic        out_valid_o;
  logic [63:0] res_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [63:0] q_exp[$];
  string       q_tag[$];
  int          q_cyc[$];

  always #2.5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  pf2i_conv dut (.*);

  function automatic real pow2(int k);
    real p = 1.0;
    if (k >= 0) for (int i = 0; i < k; i++) p = p * 2.0;
    else        for (int i = 0; i < -k; i++) p = p / 2.0;
    return p;
  endfunction

  function automatic logic [31:0] ref_lane(logic [31:0] b, logic [1:0] m, logic [1:0] rc);
    real v, r, fl;
    int  e = int'(b[30:23]);
    if (e == 0) v = real'(b[22:0]) * pow2(-149);
    else        v = (1.0 + real'(b[22:0]) * pow2(-23)) * pow2(e - 127);
    if (b[31]) v = -v;
    if (m[1] == 1'b0) begin
      if (e == 255) return 32'h8000_0000;
      fl = $floor(v);
      if (m == 2'd1 || rc == 2'd3) r = (v < 0.0) ? $ceil(v) : fl;
      else if (rc == 2'd1) r = fl;
      else if (rc == 2'd2) r = $ceil(v);
      else if (v - fl > 0.5) r = fl + 1.0;
      else if (v - fl < 0.5) r = fl;
      else r = ($floor(fl / 2.0) * 2.0 == fl) ? fl : fl + 1.0;
      if (r > 2147483647.0 || r < -2147483648.0) return 32'h8000_0000;
      return 32'(longint'(r));
    end
    r = (v < 0.0) ? $ceil(v) : $floor(v);
    if (m == 2'd2) begin
      if (r > 2147483647.0) r = 2147483647.0;
      if (r < -2147483648.0) r = -2147483648.0;
    end else begin
      if (r > 32767.0) r = 32767.0;
      if (r < -32768.0) r = -32768.0;
    end
    return 32'(longint'(r));
  endfunction

  task automatic send(input logic [31:0] hi, input logic [31:0] lo,
                      input logic [1:0] m, input logic [1:0] rc, input string tag);
    @(negedge clk_i);
    in_valid_i = 1'b1;
    mode_i = m;
    rc_i = rc;
    op_i = {hi, lo};
    q_exp.push_back({ref_lane(hi, m, rc), ref_lane(lo, m, rc)});
    q_tag.push_back(tag);
    q_cyc.push_back(cyc);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      in_valid_i = 1'b0;
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && out_valid_o) begin
        checks++;
        if (q_exp.size() == 0) begin
          errors++;
          $display("FAIL R2 unexpected strobe res=%h expected none", res_o);
        end else begin
          logic [63:0] e;
          string t;
          int c;
          e = q_exp.pop_front();
          t = q_tag.pop_front();
          c = q_cyc.pop_front();
          if (res_o !== e) begin
            errors++;
            $display("FAIL %s res=%h expected=%h", t, res_o, e);
          end
          checks++;
          if (cyc != c + 2) begin
            errors++;
            $display("FAIL R2 latency actual=%0d expected=2", cyc - c);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired pending=%0d expected=0", q_exp.size());
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk_i);
    checks++;
    if (out_valid_o !== 1'b0 || res_o !== 64'd0) begin
      errors++;
      $display("FAIL R10 reset valid=%b res=%h expected 0/0", out_valid_o, res_o);
    end
    rst_ni = 1'b1;
    idle(2);

    // R1 distinct lanes
    send(32'h3F80_0000, 32'h4000_0000, 2'd1, 2'd0, "R1");
    idle(3);
    // R3 rounding, back to back over all rc values
    for (int rc = 0; rc < 4; rc++) begin
      send(32'hC020_0000, 32'h4020_0000, 2'd0, 2'(rc), "R3");
      send(32'hBFC0_0000, 32'h4060_0000, 2'd0, 2'(rc), "R3");
      send(32'h3F00_0000, 32'hBE99_999A, 2'd0, 2'(rc), "R3");
      send(32'h47F1_2066, 32'h3FE0_0000, 2'd0, 2'(rc), "R3");
    end
    idle(2);
    // R4 truncation ignores rc
    send(32'hC020_0000, 32'h4020_0000, 2'd1, 2'd2, "R4");
    send(32'hBFC0_0000, 32'h4060_0000, 2'd1, 2'd1, "R4");
    send(32'h3F00_0000, 32'hBE99_999A, 2'd1, 2'd0, "R4");
    send(32'h47F1_2066, 32'h3FE0_0000, 2'd1, 2'd2, "R4");
    idle(1);
    // R5 indefinite
    send(32'h7FC0_0000, 32'h7F80_0000, 2'd0, 2'd0, "R5");
    send(32'hFF80_0000, 32'h4F00_0000, 2'd1, 2'd0, "R5");
    send(32'hCF00_0000, 32'h4EFF_FFFF, 2'd1, 2'd0, "R5");
    send(32'hCF00_0001, 32'h4EFF_FFFF, 2'd0, 2'd2, "R5");
    idle(2);
    // R6 denormals
    for (int rc = 0; rc < 4; rc++) begin
      send(32'h8000_0001, 32'h0000_0001, 2'd0, 2'(rc), "R6");
      send(32'h807F_FFFF, 32'h007F_FFFF, 2'd0, 2'(rc), "R6");
    end
    send(32'h807F_FFFF, 32'h0000_0001, 2'd1, 2'd2, "R6");
    idle(1);
    // R7 legacy 32-bit
    send(32'h4F00_0000, 32'hCF80_0000, 2'd2, 2'd2, "R7");
    send(32'hC020_0000, 32'h4EFF_FFFF, 2'd2, 2'd0, "R7");
    send(32'hBF7F_FFFF, 32'h3F7F_FFFF, 2'd2, 2'd1, "R7");
    idle(2);
    // R8 legacy 16-bit
    send(32'h46FF_FF00, 32'hC700_00C0, 2'd3, 2'd0, "R8");
    send(32'hC700_0100, 32'h471C_4000, 2'd3, 2'd2, "R8");
    send(32'hC060_0000, 32'h3FC0_0000, 2'd3, 2'd0, "R8");
    send(32'hC71C_4000, 32'h4700_0000, 2'd3, 2'd1, "R8");
    idle(1);
    // R9 zeros in every mode
    for (int m = 0; m < 4; m++)
      send(32'h8000_0000, 32'h0000_0000, 2'(m), 2'(m), "R9");
    send(32'h4020_0000, 32'hC060_0000, 2'd1, 2'd0, "R10");
    idle(4);

    // R10 hold between strobes
    held = res_o;
    op_i = 64'h4F00_0000_4F00_0000;
    idle(5);
    checks++;
    if (res_o !== held || out_valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R10 hold res=%h expected=%h", res_o, held);
    end
    checks++;
    if (q_exp.size() != 0) begin
      errors++;
      $display("FAIL R2 missing results actual=%0d expected=0", q_exp.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule